// File: doc/BRIEF.md
# Software-Driven Two-Wire Bus Decoder

This block follows a two-wire serial bus that software drives by writing clock and data levels into a general-purpose output register. Every register write presents a new pair of levels together with a one-cycle write strobe. By comparing each pair with the pair from the previous write, the block detects edges and rebuilds the bus framing: start condition, address byte, write bytes, read bytes with their acknowledge slots, and stop condition. It has no bit timer of its own. Framing advances only on those writes.

On the target side, one attached device sees short strobes: a transfer start carrying the 7-bit address (bit 0 cleared) and a read flag, a data byte for writing, a request for the next read byte, and the end of a transfer. The device answers a read request in the same cycle on `tgt_rdata`. The data level that software reads back through the general-purpose input register is provided on `rd_sda`.

The states are: IDLE (bus stopped), ARMED (start seen, waiting for the first clock low), TX7 to TX0 (host shifting a byte in), ACK_IN (block acknowledging a byte), RX7 to RX0 (block presenting a read byte), and ACK_OUT (host acknowledging a read byte). Transitions: IDLE→ARMED on a data fall while the clock is high. ARMED→TX7 on a clock fall while data is low. TXn→next on a clock fall, with TX0→ACK_IN. ACK_IN→RX7 on a clock fall when the transfer reads, otherwise →TX7. RXn→next on a clock fall, with RX0→ACK_OUT. ACK_OUT→RX7 on a clock fall. Any TX, RX or ACK state→IDLE on a stop.

Top module: `i2cbb_decoder`

## Requirements
- R1: After reset the block is in IDLE with no address held, `rd_sda` is 1, and no target strobe is active. The last-seen clock and data levels reset to 1.
- R2: In IDLE, a write whose data level falls while the clock level is high moves the block to ARMED. In ARMED, a write whose clock level falls while data is low moves it to TX7.
- R3: In each TX state, a clock fall shifts the data level into bit 0 of an 8-bit buffer, so the first bit sent ends up as bit 7. After TX0 the block is in ACK_IN, where `rd_sda` is 0.
- R4: On a clock fall in ACK_IN with no address held, the buffer becomes the held address. `tgt_start` pulses with `tgt_addr` equal to the buffer with bit 0 cleared and `tgt_is_read` equal to buffer bit 0.
- R5: On a clock fall in ACK_IN with an address already held, `tgt_wr` pulses with `tgt_wdata` equal to the buffer.
- R6: On a clock fall in ACK_IN when held address bit 0 is 1, `tgt_rd_req` pulses, the buffer loads `tgt_rdata` and the block enters RX7. In RX states `rd_sda` shows buffer bit 7, and each clock fall shifts the buffer left by one, so the byte appears MSB first.
- R7: A clock fall in RX0 enters ACK_OUT, where `rd_sda` is 1. A clock fall in ACK_OUT pulses `tgt_rd_req`, loads the next byte and returns to RX7.
- R8: In any TX, RX or ACK state, a data rise while the clock is high is a stop. The block returns to IDLE and clears the held address. `tgt_end` pulses only if an address was held.
- R9: Edges are detected only against the levels of the previous strobed write. Level changes without `wr_stb` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | Output-register write strobe, one cycle per write |
| sda_lvl | input | 1 | Data level carried by the write |
| scl_lvl | input | 1 | Clock level carried by the write |
| rd_sda | output | 1 | Data level that software reads back |
| tgt_start | output | 1 | Transfer start strobe |
| tgt_addr | output | 8 | Address of the started transfer, bit 0 cleared |
| tgt_is_read | output | 1 | Started transfer is a read |
| tgt_wr | output | 1 | Write-byte strobe |
| tgt_wdata | output | 8 | Byte being written |
| tgt_rd_req | output | 1 | Request for the next read byte |
| tgt_rdata | input | 8 | Read byte returned by the target in the same cycle |
| tgt_end | output | 1 | End-of-transfer strobe |

## Verification
On every cycle, the assertions check these properties. The state never moves without a strobe. At most one of start, write and end strobes fires at a time. A started address always has bit 0 clear. An end or read request is followed by IDLE or RX7 respectively. IDLE never holds an address. Only the directed scenarios can show the bit order of shifted and presented bytes, the exact address and data values on the target side, and the acknowledge levels. They also show that a stop before any address produces no end strobe, and that clock wiggles without a strobe leave the byte position untouched.

// File: rtl/i2cbb_pkg.sv
package i2cbb_pkg;

    localparam int BYTE_W  = 8;
    localparam int STATE_W = 5;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 5'd0,
        ST_ARMED   = 5'd1,
        ST_TX7     = 5'd2,
        ST_TX6     = 5'd3,
        ST_TX5     = 5'd4,
        ST_TX4     = 5'd5,
        ST_TX3     = 5'd6,
        ST_TX2     = 5'd7,
        ST_TX1     = 5'd8,
        ST_TX0     = 5'd9,
        ST_ACK_IN  = 5'd10,
        ST_RX7     = 5'd11,
        ST_RX6     = 5'd12,
        ST_RX5     = 5'd13,
        ST_RX4     = 5'd14,
        ST_RX3     = 5'd15,
        ST_RX2     = 5'd16,
        ST_RX1     = 5'd17,
        ST_RX0     = 5'd18,
        ST_ACK_OUT = 5'd19
    } bus_state_t;

endpackage

// File: rtl/i2cbb_edge_det.sv
module i2cbb_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic sda_lvl,
    input  logic scl_lvl,
    output logic sda_fall,
    output logic sda_rise,
    output logic scl_fall
);
    logic last_sda_q;
    logic last_scl_q;

    // Levels of the previous strobed write; both start high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_sda_q <= 1'b1;
            last_scl_q <= 1'b1;
        end else if (wr_stb) begin
            last_sda_q <= sda_lvl;
            last_scl_q <= scl_lvl;
        end
    end

    always_comb begin
        sda_fall = wr_stb &  last_sda_q & ~sda_lvl;
        sda_rise = wr_stb & ~last_sda_q &  sda_lvl;
        scl_fall = wr_stb &  last_scl_q & ~scl_lvl;
    end

    // R9
    no_edge_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> !(sda_fall || sda_rise || scl_fall));

endmodule

// File: rtl/i2cbb_fsm.sv
module i2cbb_fsm
    import i2cbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              sda_lvl,
    input  logic              scl_lvl,
    input  logic              sda_fall,
    input  logic              sda_rise,
    input  logic              scl_fall,
    input  logic [BYTE_W-1:0] tgt_rdata,
    output bus_state_t        state,
    output logic [BYTE_W-1:0] shift_buf,
    output logic              tgt_start,
    output logic [BYTE_W-1:0] tgt_addr,
    output logic              tgt_is_read,
    output logic              tgt_wr,
    output logic [BYTE_W-1:0] tgt_wdata,
    output logic              tgt_rd_req,
    output logic              tgt_end
);
    bus_state_t        state_q, state_n;
    logic [BYTE_W-1:0] buf_q, buf_n;
    logic [BYTE_W-1:0] addr_q, addr_n;
    logic              addr_vld_q, addr_vld_n;
    logic              stop_cond;
    logic              read_xfer;

    assign stop_cond = sda_rise & scl_lvl;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            buf_q      <= '0;
            addr_q     <= '0;
            addr_vld_q <= 1'b0;
        end else begin
            state_q    <= state_n;
            buf_q      <= buf_n;
            addr_q     <= addr_n;
            addr_vld_q <= addr_vld_n;
        end
    end

    // Next-state and target-strobe process
    always_comb begin
        state_n     = state_q;
        buf_n       = buf_q;
        addr_n      = addr_q;
        addr_vld_n  = addr_vld_q;
        tgt_start   = 1'b0;
        tgt_addr    = {buf_q[BYTE_W-1:1], 1'b0};
        tgt_is_read = buf_q[0];
        tgt_wr      = 1'b0;
        tgt_wdata   = buf_q;
        tgt_rd_req  = 1'b0;
        tgt_end     = 1'b0;
        read_xfer   = addr_vld_q ? addr_q[0] : buf_q[0];
        if (wr_stb) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sda_fall && scl_lvl) state_n = ST_ARMED;
                end
                ST_ARMED: begin
                    if (scl_fall && !sda_lvl) state_n = ST_TX7;
                end
                ST_TX7, ST_TX6, ST_TX5, ST_TX4,
                ST_TX3, ST_TX2, ST_TX1, ST_TX0: begin
                    if (scl_fall) begin
                        buf_n   = {buf_q[BYTE_W-2:0], sda_lvl};
                        state_n = bus_state_t'(state_q + 5'd1);
                    end else if (stop_cond) begin
                        state_n    = ST_IDLE;
                        addr_vld_n = 1'b0;
                        tgt_end    = addr_vld_q;
                    end
                end
                ST_ACK_IN: begin
                    if (scl_fall) begin
                        if (!addr_vld_q) begin
                            addr_vld_n = 1'b1;
                            addr_n     = buf_q;
                            tgt_start  = 1'b1;
                        end else begin
                            tgt_wr = 1'b1;
                        end
                        if (read_xfer) begin
                            tgt_rd_req = 1'b1;
                            buf_n      = tgt_rdata;
                            state_n    = ST_RX7;
                        end else begin
                            state_n = ST_TX7;
                        end
                    end else if (stop_cond) begin
                        state_n    = ST_IDLE;
                        addr_vld_n = 1'b0;
                        tgt_end    = addr_vld_q;
                    end
                end
                ST_RX7, ST_RX6, ST_RX5, ST_RX4,
                ST_RX3, ST_RX2, ST_RX1, ST_RX0: begin
                    if (scl_fall) begin
                        buf_n   = {buf_q[BYTE_W-2:0], 1'b0};
                        state_n = bus_state_t'(state_q + 5'd1);
                    end else if (stop_cond) begin
                        state_n    = ST_IDLE;
                        addr_vld_n = 1'b0;
                        tgt_end    = addr_vld_q;
                    end
                end
                ST_ACK_OUT: begin
                    if (scl_fall) begin
                        tgt_rd_req = 1'b1;
                        buf_n      = tgt_rdata;
                        state_n    = ST_RX7;
                    end else if (stop_cond) begin
                        state_n    = ST_IDLE;
                        addr_vld_n = 1'b0;
                        tgt_end    = addr_vld_q;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    assign state     = state_q;
    assign shift_buf = buf_q;

    // R9
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(state_q));

    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tgt_start, tgt_wr, tgt_end}));

    // R4
    addr_lsb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_start |-> !tgt_addr[0]);

    // R8
    end_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_end |=> state_q == ST_IDLE);

    // R8
    idle_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> !addr_vld_q);

    // R6
    fetch_to_rx7_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rd_req |=> state_q == ST_RX7);

endmodule

// File: rtl/i2cbb_readback.sv
module i2cbb_readback
    import i2cbb_pkg::*;
(
    input  bus_state_t        state,
    input  logic [BYTE_W-1:0] shift_buf,
    output logic              rd_sda
);
    always_comb begin
        unique case (state)
            ST_RX7, ST_RX6, ST_RX5, ST_RX4,
            ST_RX3, ST_RX2, ST_RX1, ST_RX0: rd_sda = shift_buf[BYTE_W-1];
            ST_ACK_IN:                      rd_sda = 1'b0;
            default:                        rd_sda = 1'b1;
        endcase
    end
endmodule

// File: rtl/i2cbb_decoder.sv
module i2cbb_decoder
    import i2cbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              sda_lvl,
    input  logic              scl_lvl,
    output logic              rd_sda,
    output logic              tgt_start,
    output logic [BYTE_W-1:0] tgt_addr,
    output logic              tgt_is_read,
    output logic              tgt_wr,
    output logic [BYTE_W-1:0] tgt_wdata,
    output logic              tgt_rd_req,
    input  logic [BYTE_W-1:0] tgt_rdata,
    output logic              tgt_end
);
    logic              sda_fall, sda_rise, scl_fall;
    bus_state_t        state;
    logic [BYTE_W-1:0] shift_buf;

    i2cbb_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .sda_lvl  (sda_lvl),
        .scl_lvl  (scl_lvl),
        .sda_fall (sda_fall),
        .sda_rise (sda_rise),
        .scl_fall (scl_fall)
    );

    i2cbb_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .sda_lvl     (sda_lvl),
        .scl_lvl     (scl_lvl),
        .sda_fall    (sda_fall),
        .sda_rise    (sda_rise),
        .scl_fall    (scl_fall),
        .tgt_rdata   (tgt_rdata),
        .state       (state),
        .shift_buf   (shift_buf),
        .tgt_start   (tgt_start),
        .tgt_addr    (tgt_addr),
        .tgt_is_read (tgt_is_read),
        .tgt_wr      (tgt_wr),
        .tgt_wdata   (tgt_wdata),
        .tgt_rd_req  (tgt_rd_req),
        .tgt_end     (tgt_end)
    );

    i2cbb_readback u_rb (
        .state     (state),
        .shift_buf (shift_buf),
        .rd_sda    (rd_sda)
    );

    // R3
    ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_start || tgt_wr) |-> $past(rd_sda) == 1'b0);

endmodule

// File: tb/i2cbb_decoder_tb.sv
`timescale 1ns/1ps
module i2cbb_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic       sda_i = 1'b1;
    logic       scl_i = 1'b1;
    logic       rd_sda;
    logic       tgt_start, tgt_is_read, tgt_wr, tgt_rd_req, tgt_end;
    logic [7:0] tgt_addr, tgt_wdata;
    logic [7:0] tgt_rdata = 8'h00;

    int n_chk = 0;
    int n_fail = 0;

    int   ev_start, ev_wr, ev_rd, ev_end;
    logic [7:0] last_addr, last_wdata;
    logic       last_rd;

    always #5 clk = ~clk;

    i2cbb_decoder dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .sda_lvl     (sda_i),
        .scl_lvl     (scl_i),
        .rd_sda      (rd_sda),
        .tgt_start   (tgt_start),
        .tgt_addr    (tgt_addr),
        .tgt_is_read (tgt_is_read),
        .tgt_wr      (tgt_wr),
        .tgt_wdata   (tgt_wdata),
        .tgt_rd_req  (tgt_rd_req),
        .tgt_rdata   (tgt_rdata),
        .tgt_end     (tgt_end)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_ev();
        ev_start = 0; ev_wr = 0; ev_rd = 0; ev_end = 0;
    endtask

    task automatic wr(input logic d, input logic c);
        @(negedge clk);
        sda_i  = d;
        scl_i  = c;
        wr_stb = 1'b1;
        #1;
        if (tgt_start) begin ev_start++; last_addr = tgt_addr; last_rd = tgt_is_read; end
        if (tgt_wr)    begin ev_wr++;    last_wdata = tgt_wdata; end
        if (tgt_rd_req) ev_rd++;
        if (tgt_end)    ev_end++;
        @(posedge clk);
        #1 wr_stb = 1'b0;
    endtask

    task automatic bus_start();
        wr(1, 1); wr(0, 1); wr(0, 0);
    endtask

    task automatic bus_stop();
        wr(0, 0); wr(0, 1); wr(1, 1);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wr(b[i], 0); wr(b[i], 1); wr(b[i], 0);
        end
    endtask

    task automatic clk_pulse();
        wr(1, 0); wr(1, 1); wr(1, 0);
    endtask

    task automatic t_reset();
        check("R1 rd_sda after reset", rd_sda, 1);
        check("R1 strobes idle", {tgt_start, tgt_wr, tgt_rd_req, tgt_end}, 0);
    endtask

    task automatic t_write();
        clear_ev();
        bus_start();
        send_byte(8'h34);
        check("R3 ack low after address", rd_sda, 0);
        clk_pulse();
        check("R4 start count", ev_start, 1);
        check("R4 address", last_addr, 8'h34);
        check("R4 read flag", last_rd, 0);
        check("R2 back to TX: rd_sda high", rd_sda, 1);
        send_byte(8'hC3);
        check("R3 ack low after data", rd_sda, 0);
        clk_pulse();
        check("R5 write count", ev_wr, 1);
        check("R5 write data", last_wdata, 8'hC3);
        bus_stop();
        check("R8 end count", ev_end, 1);
        check("R8 idle rd_sda", rd_sda, 1);
    endtask

    task automatic t_read();
        logic [7:0] b;
        clear_ev();
        bus_start();
        send_byte(8'h35);
        tgt_rdata = 8'hA5;
        clk_pulse();
        check("R4 read start addr", last_addr, 8'h34);
        check("R4 read flag", last_rd, 1);
        check("R6 fetch count", ev_rd, 1);
        check("R5 no write on address", ev_wr, 0);
        b = 8'hA5;
        for (int i = 7; i >= 0; i--) begin
            check("R6 read bit", rd_sda, b[i]);
            if (i == 5) begin
                // R9: wiggle levels without strobe
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    scl_i = k[0];
                    sda_i = ~k[0];
                end
                #1 check("R9 no advance without strobe", rd_sda, b[i]);
            end
            wr(1, 1); wr(1, 0);
        end
        check("R7 ack slot high", rd_sda, 1);
        tgt_rdata = 8'h3C;
        wr(1, 1); wr(1, 0);
        check("R7 second fetch", ev_rd, 2);
        check("R7 next byte bit7", rd_sda, 0);
        wr(1, 1); wr(1, 0); wr(1, 1); wr(1, 0);
        check("R6 next byte bit5", rd_sda, 1);
        bus_stop();
        check("R8 end after read", ev_end, 1);
        check("R8 idle after read", rd_sda, 1);
    endtask

    task automatic t_stop_noaddr();
        clear_ev();
        bus_start();
        wr(1, 0); wr(1, 1); wr(1, 0);
        wr(0, 0); wr(0, 1); wr(0, 0);
        bus_stop();
        check("R8 no end without address", ev_end, 0);
        bus_start();
        send_byte(8'h50);
        clk_pulse();
        check("R2 restart gives start", ev_start, 1);
        check("R8 address cleared by stop", last_addr, 8'h50);
        bus_stop();
        check("R8 end after restart", ev_end, 1);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        clear_ev();
        last_addr = 0; last_wdata = 0; last_rd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_stop_noaddr();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule